// File: doc/BRIEF.md
# In-order multi-issue hazard checker

This block is the issue stage of a statically scheduled superscalar pipeline. A packet of up to `SLOTS` decoded instructions arrives over a valid/ready stream and is held in a packet register. Every cycle one combinational network examines each still-unissued slot. It compares the slot against the results that are still in the execute phase, which a per-register countdown scoreboard tracks. It also compares the slot against the earlier slots of the same packet. The block then issues the longest run of hazard-free slots that starts at the oldest unissued one.

The issued slots are flagged in `iss_mask` and counted in `iss_count`. The held packet is echoed on `iss_slots` so the execution side can pick up the flagged entries. Slots that cannot issue stay in the packet register and are examined again the next cycle. A new packet is accepted only in a cycle in which every remaining slot of the held one issues.

Back-pressure rules: `in_ready` is high when no slot would be left over after this cycle's issue. A transfer happens on a clock edge with `in_valid && in_ready`. The producer holds `in_slots` and `pair_mode` stable while `in_valid` is high and `in_ready` is low. The issue side has no ready signal, because the execution units always take what is flagged.

Each slot is `SLOT_BITS` = 20 bits wide. Slot i occupies `in_slots[i*20 +: 20]`. The fields are ordered from MSB to LSB as present(1), is_fp(1), dst(5), src0(5), src1(5), lat(3). Here `lat` is the number of cycles the result stays unavailable after the issue edge.

Top module: `hzc_issue_top`

## Requirements
- R1: After reset no slot is held, `iss_mask` is 0, `iss_count` is 0 and `in_ready` is 1. A packet is loaded on an edge with `in_valid && in_ready`, and it is first examined in the following cycle.
- R2: `iss_count` equals the number of set bits in `iss_mask`. When a packet has no hazard, all of its present slots issue in its first examined cycle.
- R3: A slot does not issue while its src0 or src1 register has a nonzero remaining latency in the scoreboard.
- R4: Issuing a slot with `lat`=L sets its dst countdown to L on the issue edge, and the countdown then drops by one per cycle. A consumer can therefore issue L+1 cycles after the producer's issue cycle, and with L=0 it can issue in the very next cycle.
- R5: A slot does not issue while an earlier live slot of the same packet writes one of its source registers.
- R6: A slot does not issue while the scoreboard countdown of its dst register is greater than the slot's own `lat`.
- R7: A slot does not issue while an earlier live slot of the same packet writes the same dst register.
- R8: Issue is in program order. A blocked live slot blocks every later slot in that cycle, and no issued slot lies above an unissued live slot.
- R9: Unissued slots remain held with `iss_slots` unchanged, and they are re-examined the next cycle. An issued slot is never flagged again. `in_ready` is high exactly when no live slot remains after this cycle's issue.
- R10: In pair mode (pair flag latched with the packet from `pair_mode`), slot 1 issues in the same cycle as a live slot 0 only if slot 0 is integer (is_fp=0) and slot 1 is floating point (is_fp=1). Otherwise slot 1 waits until slot 0 has issued.
- R11: In pair mode, slots 2 and above of the packet are ignored. They never issue, and they do not hold back `in_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_mode | input | 1 | Integer/FP pairing mode, latched with each accepted packet |
| in_valid | input | 1 | Packet offered |
| in_ready | output | 1 | Packet register can take a packet this cycle |
| in_slots | input | SLOTS*20 | Packet of decoded slots |
| iss_mask | output | SLOTS | Slots issuing this cycle |
| iss_count | output | $clog2(SLOTS+1) | Number of slots issuing this cycle |
| iss_slots | output | SLOTS*20 | Currently held packet |

## Verification
The assertions check several properties on every cycle. Every issued slot must find both sources and its destination free in the scoreboard. The issued run must never pass a held slot. A flagged slot must not be flagged again. In pair mode, a same-cycle pair must be integer-then-FP, and the upper lanes must stay dead. The held packet must stay still while `in_ready` is low. Some behaviour only the bench's scenarios can show. This covers the exact countdown timing after each latency value, the blocking caused by earlier slots within a packet, the drop of ignored lanes, and the accept-while-draining throughput, all of which the reference model checks against each cycle's mask, count and ready.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  localparam int REG_W = 5;
  localparam int NREG  = 1 << REG_W;
  localparam int LAT_W = 3;

  typedef struct packed {
    logic             present;
    logic             is_fp;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src0;
    logic [REG_W-1:0] src1;
    logic [LAT_W-1:0] lat;
  } slot_t;

  localparam int SLOT_BITS = $bits(slot_t);
endpackage

// File: rtl/hzc_scoreboard.sv
module hzc_scoreboard
  import hzc_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] wr_en,
  input  logic [REG_W-1:0] wr_dst [SLOTS],
  input  logic [LAT_W-1:0] wr_lat [SLOTS],
  output logic [LAT_W-1:0] rem    [NREG]
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic             hit;
    logic [LAT_W-1:0] new_lat;
    logic [LAT_W-1:0] cnt_q;

    always_comb begin
      hit     = 1'b0;
      new_lat = '0;
      for (int k = 0; k < SLOTS; k++) begin
        if (wr_en[k] && (wr_dst[k] == REG_W'(r))) begin
          hit     = 1'b1;
          new_lat = wr_lat[k];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (hit)          cnt_q <= new_lat;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign rem[r] = cnt_q;
  end
endmodule

// File: rtl/hzc_packet_reg.sv
module hzc_packet_reg
  import hzc_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             pair_in,
  input  slot_t            in_slots [SLOTS],
  input  logic [SLOTS-1:0] iss_mask,
  output logic             in_ready,
  output slot_t            slots_q  [SLOTS],
  output logic [SLOTS-1:0] live_q,
  output logic             pair_q
);
  logic [SLOTS-1:0] present_v;
  logic [SLOTS-1:0] lane_ok;

  for (genvar k = 0; k < SLOTS; k++) begin : g_lane
    assign present_v[k] = in_slots[k].present;
    if (k < 2) begin : g_low
      assign lane_ok[k] = 1'b1;
    end else begin : g_high
      assign lane_ok[k] = ~pair_in;
    end
  end

  assign in_ready = ((live_q & ~iss_mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q  <= '0;
      pair_q  <= 1'b0;
      slots_q <= '{default: '0};
    end else if (in_valid && in_ready) begin
      live_q  <= present_v & lane_ok;
      pair_q  <= pair_in;
      slots_q <= in_slots;
    end else begin
      live_q  <= live_q & ~iss_mask;
    end
  end

  // R9
  no_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((iss_mask != '0) && !(in_valid && in_ready)) |=> ((iss_mask & $past(iss_mask)) == '0));

  if (SLOTS > 2) begin : g_drop_chk
    // R11
    lane_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pair_q |-> (live_q[SLOTS-1:2] == '0));
  end
endmodule

// File: rtl/hzc_issue_logic.sv
module hzc_issue_logic
  import hzc_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slot_t            slots [SLOTS],
  input  logic [SLOTS-1:0] live,
  input  logic             pair,
  input  logic [LAT_W-1:0] rem   [NREG],
  output logic [SLOTS-1:0] iss_mask
);
  logic [SLOTS-1:0] act;
  logic [SLOTS-1:0] haz;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic raw_sb, waw_sb, intra, pair_bad;

    assign act[k] = live[k] & slots[k].present;

    always_comb begin
      raw_sb = (rem[slots[k].src0] != '0) || (rem[slots[k].src1] != '0);
      waw_sb = rem[slots[k].dst] > slots[k].lat;
      intra  = 1'b0;
      for (int j = 0; j < k; j++) begin
        if (act[j] && ((slots[j].dst == slots[k].src0) ||
                       (slots[j].dst == slots[k].src1) ||
                       (slots[j].dst == slots[k].dst)))
          intra = 1'b1;
      end
    end

    if (k == 1) begin : g_pair
      assign pair_bad = pair & act[0] & (slots[0].is_fp | ~slots[1].is_fp);
    end else begin : g_nopair
      assign pair_bad = 1'b0;
    end

    assign haz[k] = raw_sb | waw_sb | intra | pair_bad;
  end

  always_comb begin
    logic blk;
    blk      = 1'b0;
    iss_mask = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (act[k]) begin
        if (blk || haz[k]) blk = 1'b1;
        else               iss_mask[k] = 1'b1;
      end
    end
  end

  if (SLOTS > 1) begin : g_pair_chk
    // R10
    pair_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pair && iss_mask[0] && iss_mask[1]) |-> (!slots[0].is_fp && slots[1].is_fp));
  end
endmodule

// File: rtl/hzc_issue_top.sv
module hzc_issue_top
  import hzc_pkg::*;
#(
  parameter int SLOTS = 4,
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int PKT_W = SLOTS * SLOT_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pair_mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PKT_W-1:0] in_slots,
  output logic [SLOTS-1:0] iss_mask,
  output logic [CNT_W-1:0] iss_count,
  output logic [PKT_W-1:0] iss_slots
);
  slot_t            in_arr [SLOTS];
  slot_t            held   [SLOTS];
  logic [SLOTS-1:0] live_q;
  logic             pair_q;
  logic [LAT_W-1:0] rem    [NREG];
  logic [REG_W-1:0] wr_dst [SLOTS];
  logic [LAT_W-1:0] wr_lat [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_pack
    assign in_arr[k] = slot_t'(in_slots[k*SLOT_BITS +: SLOT_BITS]);
    assign iss_slots[k*SLOT_BITS +: SLOT_BITS] = held[k];
    assign wr_dst[k] = held[k].dst;
    assign wr_lat[k] = held[k].lat;
  end

  hzc_packet_reg #(.SLOTS(SLOTS)) u_pkt (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .pair_in  (pair_mode),
    .in_slots (in_arr),
    .iss_mask (iss_mask),
    .in_ready (in_ready),
    .slots_q  (held),
    .live_q   (live_q),
    .pair_q   (pair_q)
  );

  hzc_issue_logic #(.SLOTS(SLOTS)) u_issue (
    .clk      (clk),
    .rst_n    (rst_n),
    .slots    (held),
    .live     (live_q),
    .pair     (pair_q),
    .rem      (rem),
    .iss_mask (iss_mask)
  );

  hzc_scoreboard #(.SLOTS(SLOTS)) u_sb (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (iss_mask),
    .wr_dst (wr_dst),
    .wr_lat (wr_lat),
    .rem    (rem)
  );

  always_comb begin
    iss_count = '0;
    for (int k = 0; k < SLOTS; k++) iss_count = iss_count + CNT_W'(iss_mask[k]);
  end

  logic [SLOTS-1:0] held_v;
  logic [SLOTS-1:0] low_held;
  assign held_v   = live_q & ~iss_mask;
  assign low_held = held_v & (~held_v + 1'b1);

  // R8
  prefix_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_v != '0) |-> ((iss_mask & ~(low_held - 1'b1)) == '0));

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(iss_slots));

  for (genvar k = 0; k < SLOTS; k++) begin : g_chk
    // R3
    src_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_mask[k] |-> ((rem[held[k].src0] == '0) && (rem[held[k].src1] == '0)));
    // R6
    waw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_mask[k] |-> (rem[held[k].dst] <= held[k].lat));
  end
endmodule

// File: tb/hzc_issue_top_tb_top.sv
module hzc_issue_top_tb_top;
  import hzc_pkg::*;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int SLOTS = 4;
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam int PKT_W = SLOTS * SLOT_BITS;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pair_mode = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [PKT_W-1:0] in_slots = '0;
  logic [SLOTS-1:0] iss_mask;
  logic [CNT_W-1:0] iss_count;
  logic [PKT_W-1:0] iss_slots;

  always #2.5 clk = ~clk;

  hzc_issue_top #(.SLOTS(SLOTS)) dut_i (
    .clk(clk), .rst_n(rst_n), .pair_mode(pair_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_slots(in_slots), .iss_mask(iss_mask),
    .iss_count(iss_count), .iss_slots(iss_slots)
  );

  typedef struct {
    slot_t s[SLOTS];
    bit    pair;
    string tag;
  } pkt_t;

  pkt_t  q[$];
  int    checks = 0;
  int    failures = 0;
  int    rem_m[NREG];
  slot_t m_slots[SLOTS];
  bit    m_live[SLOTS];
  bit    m_pair;
  string m_tag;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic slot_t mk(bit fp, int d, int a, int b, int l);
    slot_t s;
    s.present = 1'b1; s.is_fp = fp;
    s.dst = REG_W'(d); s.src0 = REG_W'(a); s.src1 = REG_W'(b); s.lat = LAT_W'(l);
    return s;
  endfunction

  function automatic slot_t nil();
    return '0;
  endfunction

  task automatic push(string tag, bit pair, slot_t a, slot_t b, slot_t c, slot_t d);
    pkt_t p;
    p.s[0] = a; p.s[1] = b; p.s[2] = c; p.s[3] = d;
    p.pair = pair; p.tag = tag;
    q.push_back(p);
  endtask

  // One model cycle: drive, compare, advance
  task automatic step();
    bit    exp_iss[SLOTS];
    bit    blk, haz, any_live, rdy;
    int    cnt, mask;
    string tag;
    @(negedge clk);
    if (q.size() > 0) begin
      in_valid = 1'b1; pair_mode = q[0].pair;
      for (int k = 0; k < SLOTS; k++) in_slots[k*SLOT_BITS +: SLOT_BITS] = q[0].s[k];
    end else begin
      in_valid = 1'b0; pair_mode = 1'b0; in_slots = '0;
    end
    #1;
    blk = 0; cnt = 0; mask = 0; any_live = 0; rdy = 1;
    for (int k = 0; k < SLOTS; k++) begin
      exp_iss[k] = 0;
      if (m_live[k]) begin
        any_live = 1;
        haz = (rem_m[m_slots[k].src0] > 0) || (rem_m[m_slots[k].src1] > 0) ||
              (rem_m[m_slots[k].dst] > int'(m_slots[k].lat));
        for (int j = 0; j < k; j++)
          if (m_live[j] && (m_slots[j].dst == m_slots[k].src0 ||
                            m_slots[j].dst == m_slots[k].src1 ||
                            m_slots[j].dst == m_slots[k].dst)) haz = 1;
        if (m_pair && k == 1 && m_live[0] && (m_slots[0].is_fp || !m_slots[1].is_fp)) haz = 1;
        if (blk || haz) begin blk = 1; rdy = 0; end
        else begin exp_iss[k] = 1; cnt++; mask |= (1 << k); end
      end
    end
    tag = any_live ? m_tag : (q.size() > 0 ? q[0].tag : "R1");
    chk(tag, "iss_mask", int'(iss_mask), mask);
    chk(tag, "iss_count", int'(iss_count), cnt);
    chk(tag, "in_ready", int'(in_ready), int'(rdy));
    // advance model to the state after the coming edge
    for (int r = 0; r < NREG; r++) begin
      bit hit = 0;
      for (int k = 0; k < SLOTS; k++)
        if (exp_iss[k] && m_slots[k].dst == REG_W'(r)) begin hit = 1; rem_m[r] = int'(m_slots[k].lat); end
      if (!hit && rem_m[r] > 0) rem_m[r]--;
    end
    for (int k = 0; k < SLOTS; k++) if (exp_iss[k]) m_live[k] = 0;
    if (in_valid && rdy) begin
      for (int k = 0; k < SLOTS; k++) begin
        m_slots[k] = q[0].s[k];
        m_live[k]  = q[0].s[k].present && (!q[0].pair || k < 2);
      end
      m_pair = q[0].pair; m_tag = q[0].tag;
      void'(q.pop_front());
    end
  endtask

  function automatic bit model_busy();
    for (int k = 0; k < SLOTS; k++) if (m_live[k]) return 1;
    return 0;
  endfunction

  initial begin
    int cyc;
    for (int r = 0; r < NREG; r++) rem_m[r] = 0;
    for (int k = 0; k < SLOTS; k++) begin m_live[k] = 0; m_slots[k] = '0; end
    m_pair = 0; m_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1", "reset in_ready", int'(in_ready), 1);
    chk("R1", "reset iss_mask", int'(iss_mask), 0);
    chk("R1", "reset iss_count", int'(iss_count), 0);

    push("R2", 0, mk(0,1,2,3,1), mk(1,4,5,6,2), mk(0,7,2,5,1), mk(1,8,3,6,0));
    push("R5", 0, mk(0,10,2,3,2), mk(0,11,10,3,1), mk(0,18,2,3,0), nil());
    push("R8", 0, mk(0,19,20,21,0), mk(0,22,19,20,0), mk(0,23,20,21,0), mk(0,24,20,21,0));
    push("R3", 0, mk(0,12,20,21,4), nil(), nil(), nil());
    push("R3", 0, mk(0,25,20,12,1), nil(), nil(), nil());
    push("R4", 0, mk(0,13,20,21,0), nil(), nil(), nil());
    push("R4", 0, mk(0,26,13,21,0), nil(), nil(), nil());
    push("R4", 0, mk(0,27,20,21,2), nil(), nil(), nil());
    push("R4", 0, mk(0,28,27,21,0), nil(), nil(), nil());
    push("R6", 0, mk(0,14,20,21,6), nil(), nil(), nil());
    push("R6", 0, mk(0,14,20,21,1), nil(), nil(), nil());
    push("R6", 0, mk(0,15,20,21,3), nil(), nil(), nil());
    push("R6", 0, mk(0,15,20,21,7), nil(), nil(), nil());
    push("R7", 0, mk(0,16,20,21,0), mk(1,16,20,21,0), mk(0,17,20,21,0), nil());
    push("R9", 0, mk(0,29,20,21,3), mk(0,30,29,21,0), nil(), nil());
    push("R9", 0, mk(0,31,20,21,0), nil(), nil(), nil());
    push("R10", 1, mk(0,1,20,21,0), mk(1,2,20,21,0), nil(), nil());
    push("R10", 1, mk(1,3,20,21,0), mk(0,4,20,21,0), nil(), nil());
    push("R10", 1, mk(0,5,20,21,0), mk(0,6,20,21,0), nil(), nil());
    push("R11", 1, mk(0,7,20,21,0), mk(1,8,20,21,0), mk(0,9,20,21,0), mk(0,10,20,21,0));
    push("R11", 0, mk(0,9,20,21,0), mk(0,10,9,21,0), nil(), nil());
    for (int n = 0; n < 60; n++) begin
      slot_t s[SLOTS];
      for (int k = 0; k < SLOTS; k++) begin
        s[k] = mk(1'($urandom_range(0,1)), $urandom_range(0,7), $urandom_range(0,7),
                  $urandom_range(0,7), $urandom_range(0,7));
        s[k].present = ($urandom_range(0,4) != 0);
      end
      push("R2", 1'($urandom_range(0,3) == 0), s[0], s[1], s[2], s[3]);
    end

    cyc = 0;
    while ((q.size() > 0 || model_busy()) && cyc < 5000) begin
      step();
      cyc++;
    end
    if (cyc >= 5000) begin
      failures++; checks++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 0);
    end else begin
      repeat (3) step();
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule